// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (I2C Block Protocol)

This block is the serial configuration port of a system clock generator. It sits on a two-wire I2C bus as a target. It samples SCL and SDA with its own system clock, which must run far faster than the bus. It holds the bytes that switch individual clock outputs on and off and that pick the software frequency code. Every register byte is presented in parallel on `cfg_bytes_o`, so the output gating logic can use it directly. Bit value 1 in an enable field lets the matching output toggle. Bit value 0 parks that output low.

The port accepts only one transfer shape in each direction. A write carries a command byte and a count byte, and the block acknowledges both and discards their values. The data bytes that follow are stored from register 0 upward. A read always returns a count byte first, then every register in ascending order. Register 5 also returns the five strap levels captured at power-up, inverted, so software can learn how the board was configured. The bus pins are open drain. `sda_oe_o` high means the block pulls SDA low.

There is no data stream at this block's edge. The bus sets the pace, and the block never stretches SCL, so no valid/ready pair exists and no back-pressure applies. The parallel outputs are plain levels, valid on every cycle.

Top module: `cfgi2c_top`

## Requirements
- R1: After reset the register bytes read 0x00, 0x00, 0xFF, 0x7F, 0x07 for registers 0 to 4. Register 5 bits 2:0 read 000. Register k appears on `cfg_bytes_o[8k+7:8k]`, and SDA is released.
- R2: A falling SDA while SCL is high is a start. A rising SDA while SCL is high is a stop. A stop at any point, including the middle of a byte, returns the block to idle with no register change, and the next start is served normally.
- R3: The block acknowledges only the address bytes 0xD2 (write) and 0xD3 (read). After any other address it drives nothing and ignores the bus until the next stop, and no register changes.
- R4: In a write, the two bytes after the address are acknowledged, and their values change nothing.
- R5: Write data bytes are acknowledged and stored in registers 0, 1, 2, … in that order. A stop after any whole byte leaves every register not yet reached at its old value.
- R6: Data bytes after the sixth in one write are acknowledged and change no register.
- R7: Bits 7:3 of register 5 cannot be written. They show the inverted straps: bit 7 = ~strap[0], bit 6 = ~strap[1], bit 5 = ~strap[2], bit 4 = ~strap[3], bit 3 = ~strap[4].
- R8: A read returns the byte 0x06, then registers 0 to 5, each MSB first, and each continues only after the master acknowledges.
- R9: When the master does not acknowledge a read byte, the block releases SDA and keeps it released until the next stop.
- R10: `freq_sw_o` equals register 0 bit 3, and `freq_code_o` equals register 0 bits {6,5,4,2,1}, in that order from MSB to LSB.
- R11: The block changes SDA only while SCL is low. It never drives SDA while receiving the eight bits of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 5 | Latched strap pin levels |
| sda_oe_o | output | 1 | High pulls SDA low |
| cfg_bytes_o | output | 48 | All six register bytes, register k at bits 8k+7:8k |
| freq_sw_o | output | 1 | Software frequency selection chosen |
| freq_code_o | output | 5 | Software frequency-select code |

## Verification
If the byte-role or pointer state is wrong, a register shifts by one position. This shows on `cfg_bytes_o` one system clock after the falling SCL that ends the affected byte. The full order is visible in the next read, which compares every returned byte with a model. A transmit or acknowledge phase that is out of step shows within a single bit time: an acknowledge is missing, SDA is driven during a receive bit, or SDA stays driven after a master NACK. If the strap inversion or the read-only masking is wrong, register 5 breaks both on the parallel port and in the readback.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_RX_ACK,
    PH_TX,
    PH_TX_ACK,
    PH_WAIT_STOP
  } phase_e;

  // role of the next byte received in a write transfer
  localparam logic [1:0] ROLE_ADDR = 2'd0;
  localparam logic [1:0] ROLE_CMD  = 2'd1;
  localparam logic [1:0] ROLE_CNT  = 2'd2;
  localparam logic [1:0] ROLE_DATA = 2'd3;

endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  localparam int unsigned DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0] scl_ff;
  logic [DEPTH-1:0] sda_ff;
  logic             scl_q;
  logic             sda_q;

  // an idle bus is high, so every stage resets high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[DEPTH-2:0], scl_i};
      sda_ff <= {sda_ff[DEPTH-2:0], sda_i};
      scl_q  <= scl_ff[DEPTH-1];
      sda_q  <= sda_ff[DEPTH-1];
    end
  end

  assign scl_o      = scl_ff[DEPTH-1];
  assign sda_o      = sda_ff[DEPTH-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned PTR_W    = 3,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = 48'h00_07_7F_FF_00_00,
  parameter logic [NUM_REGS*8-1:0] RO_MASK  = 48'hF8_00_00_00_00_00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_idx,
  input  logic [7:0]            wr_data,
  input  logic [NUM_REGS*8-1:0] ro_bits,
  output logic [NUM_REGS*8-1:0] regs_o
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
    localparam logic [7:0] RO  = RO_MASK[g*8 +: 8];
    localparam logic [7:0] DEF = DEFAULTS[g*8 +: 8] & ~RO;
    logic [7:0] store_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= DEF;
      end else if (wr_en && (wr_idx == PTR_W'(g))) begin
        store_q <= wr_data & ~RO;
      end
    end

    assign regs_o[g*8 +: 8] = (store_q & ~RO) | (ro_bits[g*8 +: 8] & RO);
  end

endmodule

// File: rtl/cfgi2c_proto.sv
module cfgi2c_proto
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR7 = 7'h69,
  parameter int unsigned NUM_REGS  = 6,
  parameter int unsigned PTR_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sda_s,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_det,
  input  logic                  stop_det,
  input  logic [NUM_REGS*8-1:0] rd_bytes,
  output logic                  sda_oe,
  output logic                  wr_en,
  output logic [PTR_W-1:0]      wr_idx,
  output logic [7:0]            wr_data,
  output phase_e                phase_o
);

  localparam logic [PTR_W-1:0] REG_CNT  = PTR_W'(NUM_REGS);
  localparam logic [PTR_W-1:0] TX_LAST  = PTR_W'(NUM_REGS + 1);
  localparam logic [7:0]       CNT_BYTE = 8'(NUM_REGS);

  phase_e           phase;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic             byte_done;
  logic [1:0]       role;
  logic [PTR_W-1:0] data_ptr;
  logic             is_read;
  logic [7:0]       txsh;
  logic [PTR_W-1:0] tx_idx;
  logic             mack;
  logic [PTR_W-1:0] tx_sel;
  logic [7:0]       tx_byte;

  // byte to transmit next: the count first, then registers, then all ones
  always_comb begin
    tx_sel = '0;
    if (phase == PH_TX_ACK) begin
      tx_sel = (tx_idx == TX_LAST) ? tx_idx : tx_idx + 1'b1;
    end
    if (tx_sel == '0) begin
      tx_byte = CNT_BYTE;
    end else if (tx_sel <= REG_CNT) begin
      tx_byte = rd_bytes[(int'(tx_sel) - 1) * 8 +: 8];
    end else begin
      tx_byte = 8'hFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      bitcnt    <= '0;
      shreg     <= '0;
      byte_done <= 1'b0;
      role      <= ROLE_ADDR;
      data_ptr  <= '0;
      is_read   <= 1'b0;
      txsh      <= '0;
      tx_idx    <= '0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        phase     <= PH_RX;
        bitcnt    <= '0;
        byte_done <= 1'b0;
        role      <= ROLE_ADDR;
        data_ptr  <= '0;
        is_read   <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (stop_det) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (phase)
          PH_RX: begin
            if (scl_rise && !byte_done) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              bitcnt    <= '0;
              if (role == ROLE_ADDR) begin
                if (shreg[7:1] == DEV_ADDR7) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  phase   <= PH_RX_ACK;
                end else begin
                  phase <= PH_WAIT_STOP;
                end
              end else begin
                sda_oe <= 1'b1;
                phase  <= PH_RX_ACK;
                if (role == ROLE_DATA) begin
                  wr_en   <= (data_ptr < REG_CNT);
                  wr_idx  <= data_ptr;
                  wr_data <= shreg;
                  if (data_ptr < REG_CNT) data_ptr <= data_ptr + 1'b1;
                end
              end
            end
          end
          PH_RX_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                phase  <= PH_TX;
                bitcnt <= '0;
                tx_idx <= '0;
                txsh   <= tx_byte;
                sda_oe <= ~tx_byte[7];
              end else begin
                phase  <= PH_RX;
                sda_oe <= 1'b0;
                if (role != ROLE_DATA) role <= role + 1'b1;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                sda_oe <= 1'b0;
                phase  <= PH_TX_ACK;
              end else begin
                txsh   <= {txsh[6:0], 1'b0};
                sda_oe <= ~txsh[6];
                bitcnt <= bitcnt + 1'b1;
              end
            end
          end
          PH_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                phase  <= PH_TX;
                bitcnt <= '0;
                tx_idx <= tx_sel;
                txsh   <= tx_byte;
                sda_oe <= ~tx_byte[7];
              end else begin
                phase <= PH_WAIT_STOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o = phase;

endmodule

// File: rtl/cfgi2c_top.sv
module cfgi2c_top
  import cfgi2c_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR7   = 7'h69,
  parameter int unsigned NUM_REGS    = 6,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STRAP_W     = 5,
  parameter logic [NUM_REGS*8-1:0] DEFAULTS = 48'h00_07_7F_FF_00_00
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [STRAP_W-1:0]    strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_bytes_o,
  output logic                  freq_sw_o,
  output logic [4:0]            freq_code_o
);

  localparam int unsigned PTR_W   = $clog2(NUM_REGS + 2);
  localparam int unsigned RO_BASE = (NUM_REGS - 1) * 8 + (8 - STRAP_W);
  localparam logic [NUM_REGS*8-1:0] RO_MASK =
    {{STRAP_W{1'b1}}, {(NUM_REGS*8 - STRAP_W){1'b0}}};

  logic             scl_s;
  logic             sda_s;
  logic             scl_rise;
  logic             scl_fall;
  logic             start_det;
  logic             stop_det;
  logic             wr_en;
  logic [PTR_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  phase_e           phase;
  logic [NUM_REGS*8-1:0] ro_bits;

  // straps read back inverted, strap 0 in the top bit of the last register
  always_comb begin
    ro_bits = '0;
    for (int i = 0; i < int'(STRAP_W); i++) begin
      ro_bits[RO_BASE + STRAP_W - 1 - i] = ~strap_i[i];
    end
  end

  cfgi2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  cfgi2c_proto #(
    .DEV_ADDR7 (DEV_ADDR7),
    .NUM_REGS  (NUM_REGS),
    .PTR_W     (PTR_W)
  ) proto_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_bytes  (cfg_bytes_o),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .phase_o   (phase)
  );

  cfgi2c_regbank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W),
    .DEFAULTS (DEFAULTS),
    .RO_MASK  (RO_MASK)
  ) bank_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .ro_bits (ro_bits),
    .regs_o  (cfg_bytes_o)
  );

  assign freq_sw_o   = cfg_bytes_o[3];
  assign freq_code_o = {cfg_bytes_o[6:4], cfg_bytes_o[2:1]};

endmodule

// File: rtl/cfgi2c_chk.sv
module cfgi2c_chk
  import cfgi2c_pkg::*;
#(
  parameter int unsigned NUM_REGS = 6,
  parameter int unsigned PTR_W    = 3,
  parameter logic [NUM_REGS*8-1:0] RO_MASK = '0
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_s,
  input phase_e                phase,
  input logic                  sda_oe,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_idx,
  input logic [NUM_REGS*8-1:0] regs
);

  AST_SDA_MOVES_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s) else $error("sda changed while scl high"); // R11

  AST_RX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RX) |-> !sda_oe) else $error("sda driven while receiving"); // R11

  AST_QUIET_WHEN_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE || phase == PH_WAIT_STOP) |-> !sda_oe) else $error("sda driven while unselected"); // R9

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < PTR_W'(NUM_REGS))) else $error("write past last register"); // R6

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs & ~RO_MASK)) else $error("register changed without write"); // R5

  AST_WRITE_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_s) else $error("register write while scl high"); // R5

endmodule

bind cfgi2c_top cfgi2c_chk #(
  .NUM_REGS (NUM_REGS),
  .PTR_W    (PTR_W),
  .RO_MASK  (RO_MASK)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_s  (scl_s),
  .phase  (phase),
  .sda_oe (sda_oe_o),
  .wr_en  (wr_en),
  .wr_idx (wr_idx),
  .regs   (cfg_bytes_o)
);

// File: tb/cfgi2c_top_tb_top.sv
`timescale 1ns/1ps
module cfgi2c_top_tb_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [4:0]  strap = 5'b10110;
  logic        sda_oe;
  logic [47:0] cfg_bytes;
  logic        freq_sw;
  logic [4:0]  freq_code;
  logic        sda_line;

  int nvec = 0;
  int nerr = 0;
  logic [7:0] mdl [6];
  logic [7:0] exp_q [$];
  logic [7:0] got_q [$];
  event got_ev;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  cfgi2c_top dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .sda_oe_o    (sda_oe),
    .cfg_bytes_o (cfg_bytes),
    .freq_sw_o   (freq_sw),
    .freq_code_o (freq_code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(input int k);
    if (k == 5) return {~strap[0], ~strap[1], ~strap[2], ~strap[3], ~strap[4], mdl[5][2:0]};
    return mdl[k];
  endfunction

  task automatic chk_ports(input string tag);
    for (int k = 0; k < 6; k++) chk(tag, cfg_bytes[k*8 +: 8], exp_reg(k));
    chk({tag, " R10 sw"}, {7'd0, freq_sw}, {7'd0, mdl[0][3]});
    chk({tag, " R10 code"}, {3'd0, freq_code}, {3'd0, mdl[0][6:4], mdl[0][2:1]});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    logic first;
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q/2);
    first = sda_line; tick(Q);
    b = sda_line;
    chk("R11 sda stable while scl high", {7'd0, b}, {7'd0, first});
    tick(Q/2);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      v[i] = x;
    end
    put_bit(~give_ack);
  endtask

  task automatic wr_block(input logic [7:0] addr, input logic [7:0] d [8], input int n);
    logic ack;
    bus_start();
    send_byte(addr, ack);
    if (addr == 8'hD2) begin
      chk("R3 write address ack", {7'd0, ack}, 8'd1);
      send_byte(8'hA5, ack); chk("R4 command byte ack", {7'd0, ack}, 8'd1);
      send_byte(8'h3C, ack); chk("R4 count byte ack", {7'd0, ack}, 8'd1);
      for (int i = 0; i < n; i++) begin
        send_byte(d[i], ack);
        if (i < 6) begin
          chk("R5 data ack", {7'd0, ack}, 8'd1);
          mdl[i] = (i == 5) ? (d[i] & 8'h07) : d[i];
        end else begin
          chk("R6 extra data ack", {7'd0, ack}, 8'd1);
        end
      end
    end else begin
      chk("R3 foreign address no ack", {7'd0, ack}, 8'd0);
      for (int i = 0; i < n; i++) begin
        send_byte(d[i], ack);
        chk("R3 ignored after foreign address", {7'd0, ack}, 8'd0);
      end
    end
    bus_stop();
  endtask

  // driver side of the scoreboard: expectations go in before the bytes arrive
  task automatic rd_block(input int nb, input int idle_bits);
    logic ack;
    logic [7:0] v;
    logic x;
    bus_start();
    send_byte(8'hD3, ack);
    chk("R8 read address ack", {7'd0, ack}, 8'd1);
    for (int i = 0; i < nb; i++) begin
      exp_q.push_back((i == 0) ? 8'h06 : exp_reg(i - 1));
      recv_byte(i < nb - 1, v);
      got_q.push_back(v);
      -> got_ev;
    end
    for (int i = 0; i < idle_bits; i++) begin
      get_bit(x);
      chk("R9 released after master nack", {7'd0, x}, 8'd1);
    end
    bus_stop();
  endtask

  // monitor side of the scoreboard
  initial begin
    logic [7:0] g;
    forever begin
      @(got_ev);
      while (got_q.size() > 0) begin
        g = got_q.pop_front();
        if (exp_q.size() == 0) chk("R8 unexpected read byte", g, 8'hxx);
        else chk("R8 readback byte", g, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] d [8];
    mdl[0] = 8'h00; mdl[1] = 8'h00; mdl[2] = 8'hFF;
    mdl[3] = 8'h7F; mdl[4] = 8'h07; mdl[5] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(10);

    chk_ports("R1 reset value");
    chk("R1 sda released", {7'd0, sda_oe}, 8'd0);

    d = '{8'h5A, 8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_block(8'hD2, d, 3);
    chk_ports("R5 partial write");

    d = '{8'hC3, 8'h12, 8'h0F, 8'hF0, 8'hAA, 8'hFF, 8'h55, 8'h66};
    wr_block(8'hD2, d, 8);
    chk_ports("R6 R7 full write plus extra");

    d = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_block(8'hA4, d, 3);
    chk_ports("R3 foreign address leaves registers");

    strap = 5'b01001;
    tick(4);
    chk_ports("R7 strap readback on port");
    rd_block(7, 0);

    rd_block(2, 4);

    begin : abort_mid_byte
      logic ack;
      bus_start();
      send_byte(8'hD2, ack);
      send_byte(8'h00, ack);
      send_byte(8'h00, ack);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
      bus_stop();
    end
    chk_ports("R2 stop mid byte");

    d = '{8'h08, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    wr_block(8'hD2, d, 1);
    chk_ports("R2 recovery write");
    rd_block(7, 0);

    tick(20);
    chk("R8 scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule